// File: doc/BRIEF.md
# Byte-Loaded Control Register Bank

This block is the programming front end of a video timing generator. It holds nineteen 12-bit control words: one status word and eighteen timing words. An external host writes them over an 8-bit bus using a single load strobe. The strobe idles high. On its falling edge the block samples two control pins: one says whether the cycle carries an address or data, and the other picks the low byte or the high nibble. On its rising edge the block captures the bus. The strobe is asynchronous to the system clock, so it is synchronized and edge-detected, and every register write is synchronous to the clock.

The host can address registers one at a time. It can also switch on an auto-increment mode, in which the bank takes low and high bytes in turn and steps the address after each high byte. With that mode, one address cycle followed by 38 data cycles fills the whole bank. Two address codes act as commands instead of register selects. The restart code pulses a restart indication so the timing counters reload. The clear code zeroes the whole bank. Either code freezes the block until an ordinary address is loaded. An asynchronous active-high clear input restores the power-on defaults.

Top module: `byte_regfile`

## Requirements
- R1: The address/data and byte-select pins are taken at the strobe's falling edge, and the bus value is taken at its rising edge. A pin change between the two edges does not affect that load.
- R2: Address/data = 0 marks an address cycle, which loads bus bits [5:0] as the current address. Address/data = 1 marks a data cycle. In manual mode, byte-select = 0 writes bus[7:0] into register bits [7:0], and byte-select = 1 writes bus[3:0] into bits [11:8]. The address does not change.
- R3: A falling edge with address/data = 0 and byte-select = 1 selects auto mode. A falling edge with both pins at 0 selects manual mode. Data cycles never change the mode.
- R4: In auto mode, data cycles alternate low byte then high nibble, starting with the low byte after each address cycle, and the byte-select pin is ignored. After a high nibble is written, the address steps by one, and from 18 it wraps to 0.
- R5: Address 0 selects the status word (register bits [11:0] of the flat output). Addresses 1 to 18 select the timing words, with register k at flat bits [12k+11:12k]. A data cycle at any other address changes no register.
- R6: Loading address 22 or 54 raises the restart output for one clock and sets the freeze output. No register changes.
- R7: Loading address 23 or 55 raises the clear output for one clock, zeroes all nineteen registers and sets the freeze output.
- R8: Reloading the command that is already in force gives no pulse and changes nothing. Loading any address outside the command codes drops the freeze output.
- R9: While the clear input is high, the status word holds its default (parameter, 0x000 by default), every other register is zero, the address is 0, manual mode is active and no indication is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clearIn | input | 1 | Asynchronous active-high clear to defaults |
| loadStrobe | input | 1 | Load strobe, idles high, asynchronous to clk |
| addrDataSel | input | 1 | 0 = address cycle, 1 = data cycle |
| byteSel | input | 1 | 0 = low byte, 1 = high nibble; with address it selects auto mode |
| dataBus | input | 8 | Address or data value |
| regFlat | output | 228 | All nineteen registers, register k at bits [12k+11:12k] |
| restartOut | output | 1 | One-clock pulse on entering the restart command |
| clearOut | output | 1 | One-clock pulse on entering the clear command |
| freezeOut | output | 1 | High while a command address is in force |

## Verification
The checker assumes the host holds each strobe level for several clocks, so the synchronizer sees every edge. It also assumes the control pins are steady around a falling edge and the bus is steady around a rising edge. Under those assumptions the checks on pulse width, on freezing and on zeroing hold. The bench keeps each strobe phase at least six clocks long and sets the pins three clocks before the edge that samples them. It changes them at random only in the window where R1 says they are ignored.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int NumRegs = 19;
  localparam int RegW    = 12;
  localparam int BusW    = 8;
  localparam int AddrW   = 6;
  localparam int HiW     = RegW - BusW;
  localparam int LastReg = NumRegs - 1;
  localparam int FlatW   = NumRegs * RegW;

  localparam logic [4:0] RestartCode = 5'd22;
  localparam logic [4:0] ClearCode   = 5'd23;

  typedef enum logic [1:0] {VEC_NONE, VEC_RESTART, VEC_CLEAR} vecKind_e;

  typedef struct packed {
    logic             wrLo;
    logic             wrHi;
    logic             zeroAll;
    logic [AddrW-1:0] addr;
    logic [BusW-1:0]  data;
  } wrStrobe_t;

  // command decode ignores the top address bit, so each code has two aliases
  function automatic vecKind_e decodeVec(input logic [4:0] low5);
    if (low5 == RestartCode) return VEC_RESTART;
    if (low5 == ClearCode)   return VEC_CLEAR;
    return VEC_NONE;
  endfunction
endpackage

// File: rtl/lrf_ctrl.sv
module lrf_ctrl
  import lrf_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic                clk,
  input  logic                clearIn,
  input  logic                loadStrobe,
  input  logic                addrDataSel,
  input  logic                byteSel,
  input  logic [BusW-1:0]     dataBus,
  output wrStrobe_t           strobe,
  output logic                restartPulse,
  output logic                clearPulse,
  output logic                freezeOut
);
  logic [SyncStages-1:0] syncQ;
  logic                  prevQ;
  logic                  fallEdge, riseEdge;
  logic                  adLat, byteLat, autoMode, hiNext, hiPick;
  logic [AddrW-1:0]      addrReg, nextAddr;
  vecKind_e              vecState, newKind;

  always_comb begin
    fallEdge = prevQ & ~syncQ[SyncStages-1];
    riseEdge = ~prevQ & syncQ[SyncStages-1];
    newKind  = decodeVec(dataBus[4:0]);
    hiPick   = autoMode ? hiNext : byteLat;
    nextAddr = (addrReg == AddrW'(LastReg)) ? '0 : addrReg + 1'b1;
  end

  always_ff @(posedge clk or posedge clearIn) begin
    if (clearIn) begin
      syncQ        <= '1;
      prevQ        <= 1'b1;
      adLat        <= 1'b0;
      byteLat      <= 1'b0;
      autoMode     <= 1'b0;
      hiNext       <= 1'b0;
      addrReg      <= '0;
      vecState     <= VEC_NONE;
      strobe       <= '0;
      restartPulse <= 1'b0;
      clearPulse   <= 1'b0;
    end else begin
      syncQ          <= {syncQ[SyncStages-2:0], loadStrobe};
      prevQ          <= syncQ[SyncStages-1];
      strobe.wrLo    <= 1'b0;
      strobe.wrHi    <= 1'b0;
      strobe.zeroAll <= 1'b0;
      restartPulse   <= 1'b0;
      clearPulse     <= 1'b0;
      if (fallEdge) begin
        adLat   <= addrDataSel;
        byteLat <= byteSel;
        if (!addrDataSel) autoMode <= byteSel;
      end
      if (riseEdge) begin
        if (!adLat) begin
          addrReg  <= dataBus[AddrW-1:0];
          hiNext   <= 1'b0;
          vecState <= newKind;
          if (newKind != VEC_NONE && newKind != vecState) begin
            if (newKind == VEC_RESTART) begin
              restartPulse <= 1'b1;
            end else begin
              clearPulse     <= 1'b1;
              strobe.zeroAll <= 1'b1;
            end
          end
        end else begin
          strobe.addr <= addrReg;
          strobe.data <= dataBus;
          if (hiPick) strobe.wrHi <= 1'b1;
          else        strobe.wrLo <= 1'b1;
          if (autoMode) begin
            if (hiPick) begin
              addrReg <= nextAddr;
              hiNext  <= 1'b0;
            end else begin
              hiNext  <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign freezeOut = (vecState != VEC_NONE);
endmodule

// File: rtl/lrf_datapath.sv
module lrf_datapath
  import lrf_pkg::*;
#(
  parameter logic [RegW-1:0] StatusDefault = '0
) (
  input  logic             clk,
  input  logic             clearIn,
  input  wrStrobe_t        strobe,
  output logic [FlatW-1:0] regFlat
);
  for (genvar gi = 0; gi < NumRegs; gi++) begin : g_reg
    localparam logic [RegW-1:0] Dflt = (gi == 0) ? StatusDefault : '0;
    logic [RegW-1:0] q;
    logic            hit;

    assign hit = (strobe.addr == AddrW'(gi));

    always_ff @(posedge clk or posedge clearIn) begin
      if (clearIn) begin
        q <= Dflt;
      end else if (strobe.zeroAll) begin
        q <= '0;
      end else if (hit) begin
        if (strobe.wrLo) q[BusW-1:0]    <= strobe.data;
        if (strobe.wrHi) q[RegW-1:BusW] <= strobe.data[HiW-1:0];
      end
    end

    assign regFlat[gi*RegW +: RegW] = q;
  end
endmodule

// File: rtl/byte_regfile.sv
module byte_regfile
  import lrf_pkg::*;
#(
  parameter logic [11:0] StatusDefault = 12'h000,
  parameter int          SyncStages    = 2
) (
  input  logic         clk,
  input  logic         clearIn,
  input  logic         loadStrobe,
  input  logic         addrDataSel,
  input  logic         byteSel,
  input  logic [7:0]   dataBus,
  output logic [227:0] regFlat,
  output logic         restartOut,
  output logic         clearOut,
  output logic         freezeOut
);
  wrStrobe_t wrStrobe;

  lrf_ctrl #(.SyncStages(SyncStages)) u_ctrl (
    .clk          (clk),
    .clearIn      (clearIn),
    .loadStrobe   (loadStrobe),
    .addrDataSel  (addrDataSel),
    .byteSel      (byteSel),
    .dataBus      (dataBus),
    .strobe       (wrStrobe),
    .restartPulse (restartOut),
    .clearPulse   (clearOut),
    .freezeOut    (freezeOut)
  );

  lrf_datapath #(.StatusDefault(StatusDefault)) u_dp (
    .clk     (clk),
    .clearIn (clearIn),
    .strobe  (wrStrobe),
    .regFlat (regFlat)
  );
endmodule

// File: rtl/lrf_checker.sv
module lrf_checker #(
  parameter logic [11:0] StatusDefault = 12'h000
) (
  input logic         clk,
  input logic         clearIn,
  input logic [227:0] regFlat,
  input logic         restartOut,
  input logic         clearOut,
  input logic         freezeOut
);
  // R9
  defaults_in_clear_chk: assert property (@(posedge clk)
    clearIn |-> (regFlat[11:0] == StatusDefault && regFlat[227:12] == '0 &&
                 !restartOut && !clearOut && !freezeOut));

  // R6
  restart_freezes_chk: assert property (@(posedge clk) disable iff (clearIn)
    restartOut |-> freezeOut);

  // R6
  restart_keeps_regs_chk: assert property (@(posedge clk) disable iff (clearIn)
    restartOut |=> $stable(regFlat));

  // R7
  clear_freezes_chk: assert property (@(posedge clk) disable iff (clearIn)
    clearOut |-> freezeOut);

  // R7
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (clearIn)
    clearOut |=> (regFlat == '0));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (clearIn)
    (restartOut || clearOut) |=> (!restartOut && !clearOut));

  // R8
  frozen_stable_chk: assert property (@(posedge clk) disable iff (clearIn)
    (freezeOut && $past(freezeOut) && !$past(clearOut)) |-> $stable(regFlat));
endmodule

bind byte_regfile lrf_checker #(.StatusDefault(StatusDefault)) u_chk (
  .clk        (clk),
  .clearIn    (clearIn),
  .regFlat    (regFlat),
  .restartOut (restartOut),
  .clearOut   (clearOut),
  .freezeOut  (freezeOut)
);

// File: tb/byte_regfile_tb.sv
`timescale 1ns/1ps
module byte_regfile_tb;
  logic         clk = 1'b0;
  logic         clearIn = 1'b1;
  logic         loadStrobe = 1'b1;
  logic         addrDataSel = 1'b0;
  logic         byteSel = 1'b0;
  logic [7:0]   dataBus = '0;
  logic [227:0] regFlat;
  logic         restartOut, clearOut, freezeOut;

  byte_regfile u_dut (
    .clk(clk), .clearIn(clearIn), .loadStrobe(loadStrobe),
    .addrDataSel(addrDataSel), .byteSel(byteSel), .dataBus(dataBus),
    .regFlat(regFlat), .restartOut(restartOut), .clearOut(clearOut),
    .freezeOut(freezeOut)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int mReg [19];
  int mAddr;
  bit mAuto, mHiNext, mAdLat, mByteLat;
  int mVec;
  int expRestart = 0, expClear = 0;
  int seenRestart = 0, seenClear = 0;

  always @(negedge clk) begin
    if (restartOut) seenRestart++;
    if (clearOut)   seenClear++;
  end

  function automatic int vecOf(input int a);
    if ((a & 31) == 22) return 1;
    if ((a & 31) == 23) return 2;
    return 0;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < 19; i++) mReg[i] = 0;
    mAddr = 0; mAuto = 0; mHiNext = 0; mAdLat = 0; mByteLat = 0; mVec = 0;
  endtask

  task automatic modelFall(input bit ad, input bit bs);
    mAdLat = ad; mByteLat = bs;
    if (!ad) mAuto = bs;
  endtask

  task automatic modelRise(input int d);
    int k;
    bit hi;
    if (!mAdLat) begin
      mAddr = d & 63; mHiNext = 0;
      k = vecOf(mAddr);
      if (k != 0 && k != mVec) begin
        if (k == 1) expRestart++;
        else begin
          expClear++;
          for (int i = 0; i < 19; i++) mReg[i] = 0;
        end
      end
      mVec = k;
    end else begin
      hi = mAuto ? mHiNext : mByteLat;
      if (mAddr < 19) begin
        if (hi) mReg[mAddr] = (mReg[mAddr] & 'hFF) | ((d & 'hF) << 8);
        else    mReg[mAddr] = (mReg[mAddr] & 'hF00) | (d & 'hFF);
      end
      if (mAuto) begin
        if (hi) begin mAddr = (mAddr == 18) ? 0 : ((mAddr + 1) & 63); mHiNext = 0; end
        else mHiNext = 1;
      end
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < 19; i++)
      check(req, $sformatf("reg%0d", i), int'(regFlat[i*12 +: 12]), mReg[i]);
    check(req, "freeze", int'(freezeOut), int'(mVec != 0));
    check(req, "restart count", seenRestart, expRestart);
    check(req, "clear count", seenClear, expClear);
  endtask

  task automatic doLoad(input bit ad, input bit bs, input int d, input bit flip);
    addrDataSel = ad; byteSel = bs;
    repeat (3) @(negedge clk);
    loadStrobe = 1'b0;
    repeat (6) @(negedge clk);
    modelFall(ad, bs);
    if (flip) begin addrDataSel = ~ad; byteSel = ~bs; end
    dataBus = d[7:0];
    repeat (3) @(negedge clk);
    loadStrobe = 1'b1;
    repeat (8) @(negedge clk);
    modelRise(d);
  endtask

  task automatic hardClear();
    clearIn = 1'b1;
    repeat (3) @(negedge clk);
    modelClear();
    check("R9", "status default", int'(regFlat[11:0]), 0);
    check("R9", "freeze in clear", int'(freezeOut), 0);
    clearIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    modelClear();
    repeat (3) @(negedge clk);
    hardClear();
    checkAll("R9");

    // R2 manual writes, R1 pin flip after fall
    doLoad(0, 0, 5, 0);
    doLoad(1, 0, 'hAB, 1);
    doLoad(1, 1, 'hFC, 1);
    checkAll("R2");
    check("R2", "reg5 value", int'(regFlat[5*12 +: 12]), 'hCAB);
    check("R1", "addr pins flipped", int'(regFlat[5*12 +: 12]), 'hCAB);

    // R3/R4 auto mode with wrap past 18
    doLoad(0, 1, 17, 0);
    doLoad(1, 1, 'h11, 0);
    doLoad(1, 0, 'h02, 0);
    doLoad(1, 1, 'h33, 0);
    doLoad(1, 0, 'h04, 0);
    doLoad(1, 1, 'h55, 0);
    checkAll("R4");
    check("R4", "reg18 value", int'(regFlat[18*12 +: 12]), 'h433);
    check("R4", "wrap to reg0", int'(regFlat[11:0]), 'h055);

    // R3 back to manual: repeated low writes stay on one register
    doLoad(0, 0, 2, 0);
    doLoad(1, 0, 'h77, 0);
    doLoad(1, 0, 'h78, 0);
    checkAll("R3");
    check("R3", "reg3 untouched", int'(regFlat[3*12 +: 12]), 0);

    // R5 unmapped address
    doLoad(0, 0, 40, 0);
    doLoad(1, 0, 'hEE, 0);
    doLoad(1, 1, 'h0E, 0);
    checkAll("R5");

    // R6 restart, R8 reload alias, write while frozen, release
    doLoad(0, 0, 22, 0);
    checkAll("R6");
    doLoad(0, 0, 54, 0);
    doLoad(1, 0, 'h99, 0);
    checkAll("R8");
    doLoad(0, 0, 3, 0);
    checkAll("R8");

    // R7 clear command, alias reload
    doLoad(0, 0, 55, 0);
    checkAll("R7");
    doLoad(0, 0, 23, 0);
    checkAll("R8");
    doLoad(0, 0, 1, 0);

    // random mix
    for (int n = 0; n < 350; n++) begin
      int r = $urandom_range(0, 9);
      bit bs = 1'($urandom_range(0, 1));
      bit fl = 1'($urandom_range(0, 1));
      if (r < 2) doLoad(0, bs, (r == 0) ? $urandom_range(0, 63) : $urandom_range(0, 24), fl);
      else       doLoad(1, bs, $urandom_range(0, 255), fl);
      checkAll((r < 2) ? "R5" : "R2");
    end

    // R9 async clear leaves manual mode at address 0
    doLoad(0, 1, 9, 0);
    doLoad(1, 0, 'h12, 0);
    hardClear();
    checkAll("R9");
    doLoad(1, 0, 'h3C, 0);
    doLoad(1, 0, 'h3D, 0);
    checkAll("R9");
    check("R9", "reg0 after clear", int'(regFlat[11:0]), 'h03D);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule